// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a FIFO-based UART presents to its host and drives the single interrupt line. It watches five sources. Line-status and modem-status events are latched. Receive-data availability follows the receive FIFO fill level against a selectable trigger. A character timeout is raised when received bytes sit unread. A transmit-empty condition is latched when the transmit holding register drains. The block reports the highest-priority enabled source as a 4-bit identification code.

The receive FIFO, shift registers, baud generator and bus decoding sit outside. The surrounding UART supplies the FIFO fill level and one-cycle strobes for host reads and writes of the relevant registers. It also supplies a one-cycle tick per character time and the raw serial input line. The timeout timer sees that line only through an internal synchronizer chain, so a line edge close to the clock cannot corrupt the timer.

Top module: `uart_intr_id`

## Requirements
- R1: After reset, intId is 4'b0001 (nothing pending) and intOut is 0.
- R2: Among enabled pending sources, intId shows the one with the highest priority: line status (4'b0110), then receive data (4'b0100), then character timeout (4'b1100), then transmit empty (4'b0010), then modem status (4'b0000).
- R3: With dmaMode = 0, receive data is available when rxLevel is at least the trigger. trigSel 2'b00, 2'b01, 2'b10 and 2'b11 select 1, 4, 8 and 16 bytes, so a single byte does not raise it at triggers 4, 8 or 16.
- R4: With dmaMode = 1, receive data is available whenever rxLevel is nonzero, whatever trigSel says.
- R5: A timeout becomes pending on the 4th charTick with rxLevel nonzero and no receive activity. Ticks while rxLevel is zero have no effect.
- R6: A pulse on rdRxBuf, or any change of rxLevel, clears a pending timeout and restarts the count of character times.
- R7: An edge on serialIn restarts the timeout count but does not clear a pending timeout. It passes a 2-stage synchronizer, so a tick at the first clock edge after the change still counts.
- R8: Transmit empty becomes pending on a 0-to-1 change of txHoldEmpty only. It clears on wrTxHold, or on rdIdent while intId shows 4'b0010. A read of intId while a higher source is shown leaves it pending.
- R9: lineEvent sets a line-status pending flag that rdLineStat clears. modemEvent sets a modem-status flag that rdModemStat clears. An event in the same cycle as its clearing read leaves the flag set.
- R10: intEnable bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Clearing a bit masks its source in the same cycle, and the source stays pending so that setting the bit again shows it.
- R11: intOut is 1 exactly when intId differs from 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLevel | input | 5 | Receive FIFO fill level, 0 to 16 |
| rdRxBuf | input | 1 | Host read of the receive buffer (one-cycle strobe) |
| txHoldEmpty | input | 1 | Transmit holding register is empty |
| wrTxHold | input | 1 | Host write of the transmit holding register |
| lineEvent | input | 1 | Line-status event pulse |
| rdLineStat | input | 1 | Host read of the line-status register |
| modemEvent | input | 1 | Modem-status event pulse |
| rdModemStat | input | 1 | Host read of the modem-status register |
| intEnable | input | 4 | Per-source interrupt enables |
| trigSel | input | 2 | Receive trigger-level select |
| dmaMode | input | 1 | 1: receive data available on any byte |
| rdIdent | input | 1 | Host read of the identification code |
| charTick | input | 1 | One pulse per character time |
| serialIn | input | 1 | Raw serial receive line (idle high) |
| intId | output | 4 | Identification code of the highest enabled pending source |
| intOut | output | 1 | Interrupt request |

## Verification
The bench sweeps every trigger select against every fill level in both DMA settings. A design that fired on one byte regardless of trigger fails there at once. It walks the timeout through empty-FIFO ticks, buffer reads, level changes and serial edges. A tick placed in the same cycle as a serial change exposes a timer fed from the unsynchronized line, because such a timer restarts too early and misses the expected timeout. A transmit-empty source that survives an identification read, or one that re-arms while the register stays empty, shows up as a stale 4'b0010 code. Every enable pattern is swept with all sources pending, which catches a wrong priority order or a mask that lags by a cycle.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LINE = 4'b0110;
  localparam logic [3:0] ID_RXD  = 4'b0100;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_TXE  = 4'b0010;
  localparam logic [3:0] ID_MDM  = 4'b0000;

  localparam int NUM_SRC = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic rxRead;
  } dpCmd_t;

  function automatic int unsigned trigBytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  // source index 0 is the highest priority
  function automatic logic [3:0] idCode(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXD;
      2:       return ID_TMO;
      3:       return ID_TXE;
      default: return ID_MDM;
    endcase
  endfunction

endpackage

// File: rtl/uart_intr_dp.sv
module uart_intr_dp
  import uart_intr_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int TMO_CHARS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [1:0]       trigSel,
  input  logic             dmaMode,
  input  logic             charTick,
  input  logic             serialIn,
  input  dpCmd_t           cmd,
  output logic             rxAvail,
  output logic             tmoPend
);

  localparam int CNT_W = $clog2(TMO_CHARS + 1);

  // serial synchronizer plus one history stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= serialIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= syncQ[s-1];
    end
  end

  logic serEdge;
  assign serEdge = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  logic [LVL_W-1:0] prevLevel;
  logic             notEmpty, fifoAct;
  logic [LVL_W-1:0] trigVal;

  assign notEmpty = (rxLevel != '0);
  assign fifoAct  = cmd.rxRead | (rxLevel != prevLevel);
  assign trigVal  = LVL_W'(trigBytes(trigSel));
  assign rxAvail  = dmaMode ? notEmpty : (rxLevel >= trigVal);

  logic [CNT_W-1:0] tickCnt;
  logic             cntRestart, tmoFire;

  assign cntRestart = fifoAct | serEdge | !notEmpty;
  assign tmoFire    = !cntRestart && charTick && (tickCnt == CNT_W'(TMO_CHARS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      tickCnt   <= '0;
      tmoPend   <= 1'b0;
    end else begin
      prevLevel <= rxLevel;
      if (cntRestart)
        tickCnt <= '0;
      else if (charTick && tickCnt != CNT_W'(TMO_CHARS))
        tickCnt <= tickCnt + 1'b1;
      if (fifoAct || !notEmpty)
        tmoPend <= 1'b0;
      else if (tmoFire)
        tmoPend <= 1'b1;
    end
  end

  assert_tmo_needs_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoPend) |-> $past(charTick));

  assert_rxread_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rxRead |=> !tmoPend);

  assert_edge_restarts_R7: assert property (@(posedge clk) disable iff (!rstN)
    serEdge |=> (tickCnt == '0));

endmodule

// File: rtl/uart_intr_ctrl.sv
module uart_intr_ctrl
  import uart_intr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txHoldEmpty,
  input  logic       wrTxHold,
  input  logic       lineEvent,
  input  logic       rdLineStat,
  input  logic       modemEvent,
  input  logic       rdModemStat,
  input  logic       rdIdent,
  input  logic       rdRxBuf,
  input  logic [3:0] intEnable,
  input  logic       rxAvail,
  input  logic       tmoPend,
  output dpCmd_t     cmd,
  output logic [3:0] intId,
  output logic       intOut
);

  assign cmd.rxRead = rdRxBuf;

  // status latches: index 0 line, index 1 modem
  logic [1:0] evtIn, clrIn, statPend;
  assign evtIn = {modemEvent, lineEvent};
  assign clrIn = {rdModemStat, rdLineStat};

  for (genvar g = 0; g < 2; g++) begin : g_stat
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)          statPend[g] <= 1'b0;
      else if (evtIn[g])  statPend[g] <= 1'b1;
      else if (clrIn[g])  statPend[g] <= 1'b0;
  end

  logic txPrev, txRise, txPend, txAck;
  assign txRise = txHoldEmpty & ~txPrev;
  assign txAck  = wrTxHold | (rdIdent && intId == ID_TXE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev <= 1'b1;
      txPend <= 1'b0;
    end else begin
      txPrev <= txHoldEmpty;
      if (txRise)     txPend <= 1'b1;
      else if (txAck) txPend <= 1'b0;
    end
  end

  logic [NUM_SRC-1:0] srcVec;
  assign srcVec = {statPend[1] & intEnable[3],
                   txPend      & intEnable[1],
                   tmoPend     & intEnable[0],
                   rxAvail     & intEnable[0],
                   statPend[0] & intEnable[2]};

  assign intOut = |srcVec;

  always_comb begin
    intId = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (srcVec[i]) intId = idCode(i);
  end

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statPend[0] && intEnable[2]) |-> intId == ID_LINE);

  assert_tx_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdent && intId == ID_TXE && !txRise) |=> !txPend);

  assert_line_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineEvent |=> statPend[0]);

  assert_modem_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    modemEvent |=> statPend[1]);

  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 4'b0000) |-> !intOut);

  assert_out_vs_id_R11: assert property (@(posedge clk) disable iff (!rstN)
    intOut == (intId != ID_NONE));

endmodule

// File: rtl/uart_intr_id.sv
module uart_intr_id
  import uart_intr_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int TMO_CHARS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             rdRxBuf,
  input  logic             txHoldEmpty,
  input  logic             wrTxHold,
  input  logic             lineEvent,
  input  logic             rdLineStat,
  input  logic             modemEvent,
  input  logic             rdModemStat,
  input  logic [3:0]       intEnable,
  input  logic [1:0]       trigSel,
  input  logic             dmaMode,
  input  logic             rdIdent,
  input  logic             charTick,
  input  logic             serialIn,
  output logic [3:0]       intId,
  output logic             intOut
);

  dpCmd_t dpCmd;
  logic   rxAvail, tmoPend;

  uart_intr_dp #(
    .LVL_W      (LVL_W),
    .TMO_CHARS  (TMO_CHARS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxLevel (rxLevel),
    .trigSel (trigSel),
    .dmaMode (dmaMode),
    .charTick(charTick),
    .serialIn(serialIn),
    .cmd     (dpCmd),
    .rxAvail (rxAvail),
    .tmoPend (tmoPend)
  );

  uart_intr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txHoldEmpty(txHoldEmpty),
    .wrTxHold   (wrTxHold),
    .lineEvent  (lineEvent),
    .rdLineStat (rdLineStat),
    .modemEvent (modemEvent),
    .rdModemStat(rdModemStat),
    .rdIdent    (rdIdent),
    .rdRxBuf    (rdRxBuf),
    .intEnable  (intEnable),
    .rxAvail    (rxAvail),
    .tmoPend    (tmoPend),
    .cmd        (dpCmd),
    .intId      (intId),
    .intOut     (intOut)
  );

endmodule

// File: tb/uart_intr_id_bench.sv
module uart_intr_id_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] rxLevel = '0;
  logic       rdRxBuf = 1'b0, txHoldEmpty = 1'b1, wrTxHold = 1'b0;
  logic       lineEvent = 1'b0, rdLineStat = 1'b0;
  logic       modemEvent = 1'b0, rdModemStat = 1'b0;
  logic [3:0] intEnable = '0;
  logic [1:0] trigSel = '0;
  logic       dmaMode = 1'b0, rdIdent = 1'b0, charTick = 1'b0, serialIn = 1'b1;
  logic [3:0] intId;
  logic       intOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  uart_intr_id u_uart_intr_id (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rdRxBuf(rdRxBuf),
    .txHoldEmpty(txHoldEmpty), .wrTxHold(wrTxHold),
    .lineEvent(lineEvent), .rdLineStat(rdLineStat),
    .modemEvent(modemEvent), .rdModemStat(rdModemStat),
    .intEnable(intEnable), .trigSel(trigSel), .dmaMode(dmaMode),
    .rdIdent(rdIdent), .charTick(charTick), .serialIn(serialIn),
    .intId(intId), .intOut(intOut)
  );

  localparam logic [4:0] E_NONE = 5'b0_0001;
  localparam logic [4:0] E_LINE = 5'b1_0110;
  localparam logic [4:0] E_RXD  = 5'b1_0100;
  localparam logic [4:0] E_TMO  = 5'b1_1100;
  localparam logic [4:0] E_TXE  = 5'b1_0010;
  localparam logic [4:0] E_MDM  = 5'b1_0000;

  function automatic logic [4:0] expect5(input logic ln, rx, tm, tx, md,
                                         input logic [3:0] en);
    if (ln && en[2])      return E_LINE;
    else if (rx && en[0]) return E_RXD;
    else if (tm && en[0]) return E_TMO;
    else if (tx && en[1]) return E_TXE;
    else if (md && en[3]) return E_MDM;
    else                  return E_NONE;
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] got;
    #1;
    got = {intOut, intId};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got {intOut,intId}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      charTick = 1'b1;
      @(negedge clk);
      charTick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    chk("R1 reset state", E_NONE);

    // R3 / R4 sweep: both DMA settings, all triggers, all levels
    intEnable = 4'b0001;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l <= 16; l++) begin
          int trig;
          @(negedge clk);
          dmaMode = d[0];
          trigSel = s[1:0];
          rxLevel = l[4:0];
          trig = (s == 0) ? 1 : (4 << (s - 1));
          if (d == 0) chk("R3 trigger level", (l >= trig) ? E_RXD : E_NONE);
          else        chk("R4 dma any byte", (l >= 1) ? E_RXD : E_NONE);
        end
    @(negedge clk);
    rxLevel = '0; dmaMode = 1'b0; trigSel = 2'd3;
    cyc(1);

    // R5: ticks with empty FIFO do nothing
    ticks(6);
    chk("R5 empty fifo ticks", E_NONE);
    rxLevel = 5'd2;
    cyc(1);
    ticks(3);
    chk("R5 three ticks", E_NONE);
    ticks(1);
    chk("R5 fourth tick", E_TMO);

    // R6: buffer read clears and restarts
    rdRxBuf = 1'b1; cyc(1); rdRxBuf = 1'b0;
    chk("R6 read clears timeout", E_NONE);
    ticks(3);
    chk("R6 restart three ticks", E_NONE);
    ticks(1);
    chk("R6 restart fourth tick", E_TMO);
    rxLevel = 5'd3;
    cyc(1);
    chk("R6 level change clears", E_NONE);

    // R7: serial edge reaches the timer only after synchronization
    ticks(3);
    serialIn = 1'b0;
    ticks(1);
    chk("R7 tick beside serial change still counts", E_TMO);
    cyc(3);
    chk("R7 serial edge keeps pending", E_TMO);
    rdRxBuf = 1'b1; cyc(1); rdRxBuf = 1'b0;
    chk("R7 cleared by read", E_NONE);
    ticks(3);
    serialIn = 1'b1;
    cyc(3);
    ticks(3);
    chk("R7 serial edge restarts count", E_NONE);
    ticks(1);
    chk("R7 timeout after restart", E_TMO);
    rxLevel = '0;
    cyc(1);
    chk("R6 empty fifo clears", E_NONE);

    // R8: transmit empty
    intEnable = 4'b0010;
    cyc(1);
    chk("R8 no pending while steady empty", E_NONE);
    txHoldEmpty = 1'b0; cyc(1); txHoldEmpty = 1'b1; cyc(1);
    chk("R8 set on empty transition", E_TXE);
    rdIdent = 1'b1; cyc(1); rdIdent = 1'b0;
    chk("R8 ident read clears", E_NONE);
    cyc(2);
    chk("R8 no re-arm while empty", E_NONE);
    txHoldEmpty = 1'b0; cyc(1); txHoldEmpty = 1'b1; cyc(1);
    chk("R8 re-armed by new transition", E_TXE);
    wrTxHold = 1'b1; cyc(1); wrTxHold = 1'b0;
    chk("R8 write clears", E_NONE);
    intEnable = 4'b0110;
    lineEvent = 1'b1; cyc(1); lineEvent = 1'b0;
    txHoldEmpty = 1'b0; cyc(1); txHoldEmpty = 1'b1; cyc(1);
    chk("R8 line above transmit", E_LINE);
    rdIdent = 1'b1; cyc(1); rdIdent = 1'b0;
    chk("R8 read while line shown", E_LINE);
    rdLineStat = 1'b1; cyc(1); rdLineStat = 1'b0;
    chk("R8 transmit survives other read", E_TXE);
    wrTxHold = 1'b1; cyc(1); wrTxHold = 1'b0;
    chk("R8 final clear", E_NONE);

    // R9 / R10: status latches and masking
    intEnable = 4'b1000;
    modemEvent = 1'b1; cyc(1); modemEvent = 1'b0;
    chk("R9 modem set", E_MDM);
    rdModemStat = 1'b1; cyc(1); rdModemStat = 1'b0;
    chk("R9 modem cleared", E_NONE);
    modemEvent = 1'b1; rdModemStat = 1'b1; cyc(1);
    modemEvent = 1'b0; rdModemStat = 1'b0;
    chk("R9 modem event wins over read", E_MDM);
    rdModemStat = 1'b1; cyc(1); rdModemStat = 1'b0;
    chk("R9 modem cleared again", E_NONE);
    intEnable = 4'b0100;
    lineEvent = 1'b1; rdLineStat = 1'b1; cyc(1);
    lineEvent = 1'b0; rdLineStat = 1'b0;
    chk("R9 line event wins over read", E_LINE);
    intEnable = 4'b0000;
    chk("R10 mask same cycle", E_NONE);
    cyc(1);
    intEnable = 4'b0100;
    chk("R10 unmask shows held source", E_LINE);
    rdLineStat = 1'b1; cyc(1); rdLineStat = 1'b0;
    chk("R9 line cleared", E_NONE);

    // R2 / R10 / R11: every enable pattern with all sources pending
    trigSel = 2'd3; dmaMode = 1'b0; rxLevel = 5'd2;
    cyc(1);
    lineEvent = 1'b1; modemEvent = 1'b1; txHoldEmpty = 1'b0;
    cyc(1);
    lineEvent = 1'b0; modemEvent = 1'b0; txHoldEmpty = 1'b1;
    cyc(1);
    ticks(4);
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      intEnable = e[3:0];
      chk("R2 R10 R11 sweep no rx", expect5(1, 0, 1, 1, 1, e[3:0]));
    end
    @(negedge clk);
    trigSel = 2'd0;
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      intEnable = e[3:0];
      chk("R2 R10 R11 sweep with rx", expect5(1, 1, 1, 1, 1, e[3:0]));
    end
    @(negedge clk);
    intEnable = 4'b1111;
    rdLineStat = 1'b1; cyc(1); rdLineStat = 1'b0;
    chk("R2 receive after line", E_RXD);
    trigSel = 2'd3;
    chk("R2 timeout after receive", E_TMO);
    rdRxBuf = 1'b1; cyc(1); rdRxBuf = 1'b0;
    chk("R2 transmit after timeout", E_TXE);
    wrTxHold = 1'b1; cyc(1); wrTxHold = 1'b0;
    chk("R2 modem last", E_MDM);
    rdModemStat = 1'b1; cyc(1); rdModemStat = 1'b0;
    chk("R11 all clear", E_NONE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule